// File: doc/BRIEF.md
# Running Rate Averager

A free-running statistics block for one detector channel. It keeps two exponentially smoothed figures. The first is an input count rate, built from single-cycle fast-trigger pulses. The second is an out-of-range fraction, built from a level flag that is high while the signal is outside the converter's range. Both figures update on a fixed long interval, whether or not an acquisition is in progress. Each update halves the sum of the previous average and the tally gathered over the interval just ended. The value reported for each figure is twice its average.

Beside the averagers sit several dead-time accumulators. Each one counts clock cycles during which its qualifier is high, in coarse units, and holds the result as a counter three words wide. A host reads that counter one word at a time through a small registered read port. Reading the most significant word freezes the two lower words, so three reads in a row always describe one instant. Software converts the raw words into physical units; the block only counts.

Top module: `running_rate_avg`

## Requirements
- R1: The update event occurs once every PERIOD clock cycles (default 2^21), first on the PERIOD-th rising edge after reset is released. `rate_o` and `oor_frac_o` change only on update edges. No run or enable input gates the updates.
- R2: The count tally is the number of clock edges during the interval at which `trig_i` is high. An event sampled on the update edge itself belongs to the next interval. On update, the new rate average is floor((old average + tally) / 2).
- R3: On the same update edge, `rate_o` becomes twice the new rate average. This value is always even and never saturates.
- R4: The out-of-range tally gains one count for every 2^OOR_SHIFT (default 64) edges at which `oor_i` is high. The remainder below one count carries into later intervals. The tally is averaged in the same halving way, and `oor_frac_o` reports twice its average.
- R5: Both tallies saturate at 2^TALLY_W−1 instead of wrapping.
- R6: Dead-time accumulator k advances by one for every 2^DT_SHIFT (default 16) edges at which `dt_qual_i[k]` is high. The remainder carries over.
- R7: Each accumulator is 3·WORD_W bits wide. Carries pass from the low word through the middle word into the high word.
- R8: A read is requested by setting `dt_rd_en_i` with a counter index in `dt_rd_sel_i` and a word code in `dt_rd_word_i`. The word codes are 0 = high, 1 = middle, 2 = low, and 3 returns zero. `dt_rd_data_o` presents the word on the edge after the request and holds it until the next request.
- R9: A high-word read returns the live high word and, on the same edge, captures the middle and low words of that counter. Later middle and low reads return the captured words, however much the counter has advanced since.
- R10: Synchronous reset clears averages, tallies, prescalers, accumulators and outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Fast-trigger pulse, counted per cycle high |
| oor_i | input | 1 | Out-of-range level flag |
| dt_qual_i | input | N_DT | One dead-time qualifier per accumulator |
| dt_rd_en_i | input | 1 | Read request strobe |
| dt_rd_sel_i | input | DT_SEL_W | Accumulator index for the read |
| dt_rd_word_i | input | 2 | Word code: 0 high, 1 middle, 2 low, 3 none |
| rate_o | output | TALLY_W+1 | Reported count rate (twice the average) |
| oor_frac_o | output | TALLY_W+1 | Reported out-of-range figure (twice the average) |
| dt_rd_data_o | output | WORD_W | Registered read word |

## Verification
A corrupted tally or average register stays hidden until the next update edge. At that edge the reported figure departs from the halving recurrence, and the error then decays by half with each later interval. A bench must therefore check several consecutive intervals with different tallies, and must also check the cycle just before each update, where a value that moves too early shows up. A lost out-of-range remainder appears only in an interval whose tally depends on the carry. A broken capture of the lower words appears only when the counter moves between the high-word read and the later reads of the lower words.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic [1:0] {
    DW_HIGH = 2'd0,
    DW_MID  = 2'd1,
    DW_LOW  = 2'd2,
    DW_NONE = 2'd3
  } dt_word_e;
endpackage

// File: rtl/ra_period_timer.sv
module ra_period_timer #(
  parameter int PERIOD = 2097152
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || tick_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R1: update events never occur back to back
  a_r1_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ra_ewma_chan.sv
module ra_ewma_chan #(
  parameter int TALLY_W   = 16,
  parameter int PRE_SHIFT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic             evt_i,
  output logic [TALLY_W:0] rep_o
);
  localparam logic [TALLY_W-1:0] TALLY_MAX = '1;

  logic               step;
  logic [TALLY_W-1:0] tally_q;
  logic [TALLY_W-1:0] avg_q;
  logic [TALLY_W:0]   sum;

  generate
    if (PRE_SHIFT == 0) begin : g_direct
      assign step = evt_i;
    end else begin : g_prescale
      logic [PRE_SHIFT-1:0] pre_q;
      assign step = evt_i && (&pre_q);
      always_ff @(posedge clk) begin
        if (rst)        pre_q <= '0;
        else if (evt_i) pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                             tally_q <= '0;
    else if (upd_i)                      tally_q <= {{(TALLY_W-1){1'b0}}, step};
    else if (step && tally_q != TALLY_MAX) tally_q <= tally_q + 1'b1;
  end

  assign sum = {1'b0, avg_q} + {1'b0, tally_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_q <= '0;
      rep_o <= '0;
    end else if (upd_i) begin
      avg_q <= sum[TALLY_W:1];
      rep_o <= {sum[TALLY_W:1], 1'b0};
    end
  end

  // R5: a full tally stays full until the interval closes
  a_r5_tally_saturates: assert property (@(posedge clk) disable iff (rst)
    (tally_q == TALLY_MAX && !upd_i) |=> tally_q == TALLY_MAX);
  // R1: reported value only moves on an update edge
  a_r1_report_holds: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(rep_o));
  // R2: new average never exceeds both of its inputs
  a_r2_avg_bounded: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> (avg_q <= $past(tally_q)) || (avg_q <= $past(avg_q)));
  // R3: report tracks the average it was updated with
  a_r3_report_double: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> rep_o == {avg_q, 1'b0});
endmodule

// File: rtl/ra_deadtime_acc.sv
module ra_deadtime_acc #(
  parameter int WORD_W   = 16,
  parameter int DT_SHIFT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  qual_i,
  input  logic                  snap_i,
  output logic [3*WORD_W-1:0]   cnt_o,
  output logic [2*WORD_W-1:0]   shadow_o
);
  logic step;

  generate
    if (DT_SHIFT == 0) begin : g_direct
      assign step = qual_i;
    end else begin : g_prescale
      logic [DT_SHIFT-1:0] pre_q;
      assign step = qual_i && (&pre_q);
      always_ff @(posedge clk) begin
        if (rst)         pre_q <= '0;
        else if (qual_i) pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       cnt_o <= '0;
    else if (step) cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         shadow_o <= '0;
    else if (snap_i) shadow_o <= cnt_o[2*WORD_W-1:0];
  end

  // R6: no qualifier, no advance
  a_r6_idle_count: assert property (@(posedge clk) disable iff (rst)
    !qual_i |=> $stable(cnt_o));
  // R9: captured words only change on a high-word read
  a_r9_shadow_holds: assert property (@(posedge clk) disable iff (rst)
    !snap_i |=> $stable(shadow_o));
endmodule

// File: rtl/running_rate_avg.sv
module running_rate_avg #(
  parameter int PERIOD    = 2097152,
  parameter int TALLY_W   = 16,
  parameter int OOR_SHIFT = 6,
  parameter int N_DT      = 2,
  parameter int WORD_W    = 16,
  parameter int DT_SHIFT  = 4,
  parameter int DT_SEL_W  = (N_DT > 1) ? $clog2(N_DT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_i,
  input  logic                oor_i,
  input  logic [N_DT-1:0]     dt_qual_i,
  input  logic                dt_rd_en_i,
  input  logic [DT_SEL_W-1:0] dt_rd_sel_i,
  input  logic [1:0]          dt_rd_word_i,
  output logic [TALLY_W:0]    rate_o,
  output logic [TALLY_W:0]    oor_frac_o,
  output logic [WORD_W-1:0]   dt_rd_data_o
);
  import ra_pkg::*;

  localparam int CW = 3 * WORD_W;

  logic              upd;
  logic [CW-1:0]     cnt_w    [N_DT];
  logic [2*WORD_W-1:0] shadow_w [N_DT];
  dt_word_e          word_sel;
  logic              sel_ok;

  ra_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst(rst), .tick_o(upd)
  );

  ra_ewma_chan #(.TALLY_W(TALLY_W), .PRE_SHIFT(0)) u_rate (
    .clk(clk), .rst(rst), .upd_i(upd), .evt_i(trig_i), .rep_o(rate_o)
  );

  ra_ewma_chan #(.TALLY_W(TALLY_W), .PRE_SHIFT(OOR_SHIFT)) u_oor (
    .clk(clk), .rst(rst), .upd_i(upd), .evt_i(oor_i), .rep_o(oor_frac_o)
  );

  assign word_sel = dt_word_e'(dt_rd_word_i);
  assign sel_ok   = (int'(dt_rd_sel_i) < N_DT);

  generate
    for (genvar k = 0; k < N_DT; k++) begin : g_dt
      logic snap;
      assign snap = dt_rd_en_i && (word_sel == DW_HIGH) &&
                    (int'(dt_rd_sel_i) == k);
      ra_deadtime_acc #(.WORD_W(WORD_W), .DT_SHIFT(DT_SHIFT)) u_acc (
        .clk(clk), .rst(rst), .qual_i(dt_qual_i[k]), .snap_i(snap),
        .cnt_o(cnt_w[k]), .shadow_o(shadow_w[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_rd_data_o <= '0;
    end else if (dt_rd_en_i) begin
      if (!sel_ok) begin
        dt_rd_data_o <= '0;
      end else begin
        case (word_sel)
          DW_HIGH: dt_rd_data_o <= cnt_w[dt_rd_sel_i][CW-1:2*WORD_W];
          DW_MID:  dt_rd_data_o <= shadow_w[dt_rd_sel_i][2*WORD_W-1:WORD_W];
          DW_LOW:  dt_rd_data_o <= shadow_w[dt_rd_sel_i][WORD_W-1:0];
          default: dt_rd_data_o <= '0;
        endcase
      end
    end
  end

  // R8: read data holds between requests
  a_r8_data_holds: assert property (@(posedge clk) disable iff (rst)
    !dt_rd_en_i |=> $stable(dt_rd_data_o));
  // R8: the unused word code reads as zero
  a_r8_none_zero: assert property (@(posedge clk) disable iff (rst)
    (dt_rd_en_i && dt_rd_word_i == 2'd3) |=> dt_rd_data_o == '0);
  // R3: reported figures are always even
  a_r3_even_reports: assert property (@(posedge clk) disable iff (rst)
    !rate_o[0] && !oor_frac_o[0]);
endmodule

// File: tb/test_running_rate_avg.sv
module test_running_rate_avg;
  localparam int P       = 512;
  localparam int TW      = 8;
  localparam int WW      = 4;
  localparam int NV      = 8;
  // per vector: trigger cycles, out-of-range cycles, expected rate, expected fraction
  localparam int VEC [NV][4] = '{
    '{10, 0, 10, 0}, '{100, 64, 104, 0}, '{300, 200, 306, 2}, '{0, 60, 152, 2},
    '{255, 500, 330, 8}, '{1, 8, 166, 4}, '{480, 480, 338, 8}, '{0, 0, 168, 4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic oor = 1'b0;
  logic [1:0] qual = 2'b00;
  logic rd_en = 1'b0;
  logic [0:0] rd_sel = 1'b0;
  logic [1:0] rd_word = 2'd0;
  logic [TW:0] rate, frac;
  logic [WW-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  running_rate_avg #(
    .PERIOD(P), .TALLY_W(TW), .OOR_SHIFT(6), .N_DT(2), .WORD_W(WW), .DT_SHIFT(4)
  ) i_running_rate_avg (
    .clk(clk), .rst(rst), .trig_i(trig), .oor_i(oor), .dt_qual_i(qual),
    .dt_rd_en_i(rd_en), .dt_rd_sel_i(rd_sel), .dt_rd_word_i(rd_word),
    .rate_o(rate), .oor_frac_o(frac), .dt_rd_data_o(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int sel, input int word, output int val);
    rd_en = 1'b1; rd_sel = sel[0:0]; rd_word = word[1:0];
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(rd_data);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev_rate = 0;
    int prev_frac = 0;
    int v;
    repeat (3) @(negedge clk);
    chk("R10 rate in reset", int'(rate), 0);
    chk("R10 fraction in reset", int'(frac), 0);
    chk("R10 read data in reset", int'(rd_data), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      for (int k = 1; k <= P; k++) begin
        trig = (k <= VEC[i][0]);
        oor  = (k <= VEC[i][1]);
        @(negedge clk);
        if (k == P - 1) begin
          chk("R1 rate steady before update", int'(rate), prev_rate);
          chk("R1 fraction steady before update", int'(frac), prev_frac);
        end
      end
      // R5 saturation is exercised by vectors 2 and 6
      chk($sformatf("R2/R3/R5 rate vector %0d", i), int'(rate), VEC[i][2]);
      chk($sformatf("R4 fraction vector %0d", i), int'(frac), VEC[i][3]);
      prev_rate = VEC[i][2];
      prev_frac = VEC[i][3];
    end

    rst = 1'b1;
    @(negedge clk);
    chk("R10 rate after reset", int'(rate), 0);
    chk("R10 fraction after reset", int'(frac), 0);
    rst = 1'b0;

    // R6/R7: 4805 qualified edges -> 300 units = 0x12C
    qual[0] = 1'b1;
    repeat (4805) @(negedge clk);
    qual[0] = 1'b0;
    rd(0, 0, v); chk("R7 high word", v, 1);
    rd(0, 1, v); chk("R7 middle word", v, 2);
    rd(0, 2, v); chk("R6 low word", v, 12);
    rd(1, 0, v); chk("R8 idle counter high", v, 0);
    rd(1, 2, v); chk("R8 idle counter low", v, 0);
    rd(0, 3, v); chk("R8 code 3 reads zero", v, 0);

    // R9: 5005 qualified edges -> 312 = 0x138 captured at the high read
    qual[0] = 1'b1;
    repeat (200) @(negedge clk);
    rd(0, 0, v); chk("R9 high word at capture", v, 1);
    repeat (100) @(negedge clk);
    rd(0, 1, v); chk("R9 middle word from capture", v, 3);
    rd(0, 2, v); chk("R9 low word from capture", v, 8);
    qual[0] = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule